// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between the data-space port of a small 8-bit processor core and an external asynchronous SRAM. Every data access whose address lies above the internal data-space range becomes a bus cycle. The upper address byte is driven on its own port. The lower address byte and the data byte take turns on one shared 8-bit bus. A latch-enable strobe tells an external transparent latch when the shared bus carries the low address. Active-low read and write strobes then move the data.

Each access uses a two-bit wait setting. There are two such settings, one for the upper sector and one for the lower sector, and a configurable boundary address decides between them. A compatibility input moves the top of the internal range. An optional bus keeper holds the last value the block drove instead of floating the shared bus.

The processor sees one `ready_o` signal. A request is accepted only while `ready_o` is high. `ready_o` drops for the whole external cycle and rises again in the cycle that completes it, and read data is valid in that same cycle.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `ready_o`=1, `rd_n_o`=1, `wr_n_o`=1, `ale_o`=0, `ahi_o`=0, and `ad_oe_o`=0 when the keeper is off.
- R2: With `compat_i`=0, addresses up to 0x10FF are internal and 0x1100 upward are external. With `compat_i`=1, the limit is 0x0FFF and 0x1000 is the first external address. An internal request leaves `ready_o` high and starts no strobe.
- R3: The first cycle after an accepted external request is the address phase: `ale_o`=1, `ad_oe_o`=1, `ad_o` = address bits 7:0, `ahi_o` = address bits 15:8, `ready_o`=0.
- R4: Wait code 00, 01, 10 and 11 holds the active strobe low for 1, 2, 3 and 3 cycles. A whole access takes 4, 5, 6 and 7 cycles, counted from the address phase through the cycle in which `ready_o` returns high.
- R5: An access uses `ws_upper_i` when its address is greater than or equal to `sector_bound_i`, and `ws_lower_i` otherwise.
- R6: During a write, `wr_n_o` is low, `rd_n_o` stays high, and `ad_o` carries the write data with `ad_oe_o`=1.
- R7: During a read, `ad_oe_o` is 0 while `rd_n_o` is low. `ad_i` is sampled in the last strobe cycle, and the sampled value appears on `rdata_o` when `ready_o` rises.
- R8: In the extra final period of a code-11 access, `ale_o` equals `nxt_ram_i`. The final cycle of any other code has `ale_o`=0.
- R9: With `keeper_en_i`=0, the bus is released (`ad_oe_o`=0) whenever it is not carrying an address or write data. With `keeper_en_i`=1, it stays driven with the last driven value at those times, except while `rd_n_o` is low.
- R10: `ahi_o` keeps the upper address byte of the previous access until the next accepted request.
- R11: A request presented in the final cycle of an access starts the next address phase in the following cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_i | input | 1 | 1 = smaller internal range (limit 0x0FFF) |
| keeper_en_i | input | 1 | Hold the last driven value on the shared bus |
| sector_bound_i | input | 16 | First address of the upper sector |
| ws_upper_i | input | 2 | Wait code for the upper sector |
| ws_lower_i | input | 2 | Wait code for the lower sector |
| req_i | input | 1 | Data-space access request (taken when `ready_o`=1) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| nxt_ram_i | input | 1 | The following access targets RAM |
| rdata_o | output | 8 | Read data |
| ready_o | output | 1 | High when idle or finishing; low while an external cycle runs |
| ale_o | output | 1 | Low-address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ahi_o | output | 8 | Upper address byte |
| ad_o | output | 8 | Shared bus, outgoing value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus, incoming value |

## Verification
Two situations are hard to reach from the ports. The first is the extra final period of a code-11 access, where the latch strobe depends on a look-ahead input. The second is a new request landing in exactly the cycle in which the previous access finishes. The bench drives the wait codes and the sector boundary so that one address pair falls on each side of the boundary. It holds `nxt_ram_i` across the final period, and it raises the next request in the very cycle it first sees `ready_o` return high. An SRAM model latches the low address on the strobe and answers reads, so write-then-read pairs prove that the bus phases line up.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_GAP,
    XS_STB,
    XS_END,
    XS_TAIL
  } xm_state_e;

  // extra strobe cycles beyond the first, per wait code
  function automatic logic [1:0] stb_extra(input logic [1:0] ws);
    case (ws)
      2'b00:   stb_extra = 2'd0;
      2'b01:   stb_extra = 2'd1;
      default: stb_extra = 2'd2;
    endcase
  endfunction

  // code 11 adds a trailing period before the next address
  function automatic logic has_tail(input logic [1:0] ws);
    has_tail = (ws == 2'b11);
  endfunction

endpackage

// File: rtl/xmem_rst_sync.sv
module xmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xmem_decode.sv
module xmem_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] INT_TOP_NORM   = 16'h10FF,
  parameter logic [AW-1:0] INT_TOP_COMPAT = 16'h0FFF
) (
  input  logic [AW-1:0] addr,
  input  logic          compat,
  input  logic [AW-1:0] bound,
  input  logic [1:0]    ws_up,
  input  logic [1:0]    ws_lo,
  output logic          is_ext,
  output logic [1:0]    ws_sel
);
  logic [AW-1:0] int_top;

  always_comb begin
    int_top = compat ? INT_TOP_COMPAT : INT_TOP_NORM;
    is_ext  = (addr > int_top);
    ws_sel  = (addr >= bound) ? ws_up : ws_lo;
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] ws_in,
  input  logic       nxt_ram,
  output xm_state_e  state,
  output logic       ready,
  output logic       ale,
  output logic       stb_act,
  output logic       stb_last
);
  xm_state_e st_q, st_d;
  logic [1:0] cnt_q, cnt_d;
  logic [1:0] ws_q, ws_d;
  logic       tail;

  assign tail = has_tail(ws_q);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ws_d  = ws_q;
    case (st_q)
      XS_IDLE: begin
        if (start) begin
          st_d = XS_ADDR;
          ws_d = ws_in;
        end
      end
      XS_ADDR: st_d = XS_GAP;
      XS_GAP: begin
        st_d  = XS_STB;
        cnt_d = stb_extra(ws_q);
      end
      XS_STB: begin
        if (cnt_q == 2'd0) st_d = XS_END;
        else               cnt_d = cnt_q - 2'd1;
      end
      XS_END: begin
        if (tail) begin
          st_d = XS_TAIL;
        end else if (start) begin
          st_d = XS_ADDR;
          ws_d = ws_in;
        end else begin
          st_d = XS_IDLE;
        end
      end
      XS_TAIL: begin
        if (start) begin
          st_d = XS_ADDR;
          ws_d = ws_in;
        end else begin
          st_d = XS_IDLE;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XS_IDLE;
      cnt_q <= 2'd0;
      ws_q  <= 2'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ws_q  <= ws_d;
    end
  end

  always_comb begin
    state    = st_q;
    ready    = (st_q == XS_IDLE) || (st_q == XS_TAIL) || ((st_q == XS_END) && !tail);
    ale      = (st_q == XS_ADDR) || ((st_q == XS_TAIL) && nxt_ram);
    stb_act  = (st_q == XS_STB);
    stb_last = (st_q == XS_STB) && (cnt_q == 2'd0);
  end
endmodule

// File: rtl/xmem_pad.sv
module xmem_pad #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          keeper_en,
  input  logic          drv_addr,
  input  logic          drv_data,
  input  logic          rd_phase,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  logic [DW-1:0] last_q, last_d;
  logic          last_en;

  always_comb begin
    if (drv_addr) begin
      ad_out = addr_lo;
      ad_oe  = 1'b1;
    end else if (drv_data) begin
      ad_out = wdata;
      ad_oe  = 1'b1;
    end else if (rd_phase) begin
      ad_out = last_q;
      ad_oe  = 1'b0;
    end else begin
      ad_out = last_q;
      ad_oe  = keeper_en;
    end
    last_en = drv_addr || drv_data;
    last_d  = ad_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (last_en) last_q <= last_d;
  end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] INT_TOP_NORM   = 16'h10FF,
  parameter logic [AW-1:0] INT_TOP_COMPAT = 16'h0FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compat_i,
  input  logic             keeper_en_i,
  input  logic [AW-1:0]    sector_bound_i,
  input  logic [1:0]       ws_upper_i,
  input  logic [1:0]       ws_lower_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             nxt_ram_i,
  output logic [DW-1:0]    rdata_o,
  output logic             ready_o,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic [AW-DW-1:0] ahi_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [DW-1:0]    ad_i
);
  localparam int HW = AW - DW;

  logic       rst_int_n;
  logic       is_ext;
  logic [1:0] ws_sel;
  logic       accept;
  xm_state_e  state;
  logic       ready, ale, stb_act, stb_last;
  logic       drv_addr, drv_data, rd_phase, sample;

  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          we_q;

  xmem_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  xmem_decode #(
    .AW(AW), .INT_TOP_NORM(INT_TOP_NORM), .INT_TOP_COMPAT(INT_TOP_COMPAT)
  ) i_decode (
    .addr  (addr_i),
    .compat(compat_i),
    .bound (sector_bound_i),
    .ws_up (ws_upper_i),
    .ws_lo (ws_lower_i),
    .is_ext(is_ext),
    .ws_sel(ws_sel)
  );

  assign accept = req_i && is_ext && ready;

  xmem_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (accept),
    .ws_in   (ws_sel),
    .nxt_ram (nxt_ram_i),
    .state   (state),
    .ready   (ready),
    .ale     (ale),
    .stb_act (stb_act),
    .stb_last(stb_last)
  );

  always_comb begin
    drv_addr = (state == XS_ADDR);
    drv_data = we_q && (stb_act || (state == XS_END));
    rd_phase = !we_q && stb_act;
    sample   = !we_q && stb_last;
  end

  xmem_pad #(.DW(DW)) i_pad (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .keeper_en(keeper_en_i),
    .drv_addr (drv_addr),
    .drv_data (drv_data),
    .rd_phase (rd_phase),
    .addr_lo  (a_q[DW-1:0]),
    .wdata    (wd_q),
    .ad_out   (ad_o),
    .ad_oe    (ad_oe_o)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      a_q  <= '0;
      wd_q <= '0;
      we_q <= 1'b0;
    end else if (accept) begin
      a_q  <= addr_i;
      wd_q <= wdata_i;
      we_q <= we_i;
    end
  end

  // read data capture
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_q <= '0;
    else if (sample) rd_q <= ad_i;
  end

  assign rdata_o = rd_q;
  assign ready_o = ready;
  assign ale_o   = ale;
  assign rd_n_o  = !(stb_act && !we_q);
  assign wr_n_o  = !(stb_act && we_q);
  assign ahi_o   = a_q[AW-1:AW-HW];
endmodule

// File: rtl/xmem_bus_chk.sv
module xmem_bus_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_o,
  input logic          ale_o,
  input logic          rd_n_o,
  input logic          wr_n_o,
  input logic          ad_oe_o,
  input logic [HW-1:0] ahi_o
);
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  a_r7_no_drive_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  a_r6_drive_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe_o);

  a_r3_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && !ready_o) |-> ad_oe_o);

  a_r11_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !ready_o);

  a_r10_ahi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !$past(ready_o)) |-> $stable(ahi_o));
endmodule

bind xmem_bus_ctrl xmem_bus_chk #(.HW(AW - DW)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ready_o(ready_o),
  .ale_o  (ale_o),
  .rd_n_o (rd_n_o),
  .wr_n_o (wr_n_o),
  .ad_oe_o(ad_oe_o),
  .ahi_o  (ahi_o)
);

// File: tb/test_xmem_bus_ctrl.sv
module test_xmem_bus_ctrl;
  logic        clk, rst_n;
  logic        compat_i, keeper_en_i, req_i, we_i, nxt_ram_i;
  logic [15:0] sector_bound_i, addr_i;
  logic [1:0]  ws_upper_i, ws_lower_i;
  logic [7:0]  wdata_i, rdata_o, ahi_o, ad_o, ad_i;
  logic        ready_o, ale_o, rd_n_o, wr_n_o, ad_oe_o;

  int total = 0, fails = 0;
  bit done = 0;

  xmem_bus_ctrl i_xmem_bus_ctrl (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // SRAM model with external address latch
  logic [7:0] mem [0:255];
  logic [7:0] lat;
  always @(posedge clk) begin
    if (ale_o) lat <= ad_o;
    if (!wr_n_o) mem[lat ^ ahi_o] <= ad_o;
  end
  assign ad_i = !rd_n_o ? mem[lat ^ ahi_o] : (ad_oe_o ? ad_o : 8'h00);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc, rdlow, wrlow, alemid, oerd;
  logic [7:0] rdv;
  logic lastale, addr_ok;

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d, input logic nxt);
    @(negedge clk);
    req_i = 1; we_i = we; addr_i = a; wdata_i = d; nxt_ram_i = nxt;
    @(negedge clk);
    req_i = 0;
    cyc = 1; rdlow = 0; wrlow = 0; alemid = 0; oerd = 0;
    addr_ok = ale_o && ad_oe_o && (ad_o == a[7:0]) && (ahi_o == a[15:8]) && !ready_o;
    while (!ready_o && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (!rd_n_o) rdlow++;
      if (!wr_n_o) wrlow++;
      if (!rd_n_o && ad_oe_o) oerd++;
      if (ale_o && !ready_o) alemid++;
    end
    lastale = ale_o;
    rdv = rdata_o;
    nxt_ram_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 ready", ready_o, 1); chk("R1 rd_n", rd_n_o, 1);
    chk("R1 wr_n", wr_n_o, 1);   chk("R1 ale", ale_o, 0);
    chk("R1 oe", ad_oe_o, 0);    chk("R1 ahi", ahi_o, 0);
  endtask

  task automatic internal_req(input logic [15:0] a, input string tag);
    @(negedge clk); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk); req_i = 0;
    chk({tag, " ready"}, ready_o, 1);
    chk({tag, " ale"}, ale_o, 0);
    @(negedge clk);
    chk({tag, " rd_n"}, rd_n_o, 1);
  endtask

  task automatic t_decode;
    sector_bound_i = 16'h8000; ws_upper_i = 2'b00; ws_lower_i = 2'b00;
    compat_i = 0;
    internal_req(16'h10FF, "R2 norm 10FF");
    access(0, 16'h1100, 0, 0);
    chk("R2 norm 1100 cycles", cyc, 4);
    compat_i = 1;
    internal_req(16'h0FFF, "R2 compat 0FFF");
    access(0, 16'h1000, 0, 0);
    chk("R2 compat 1000 cycles", cyc, 4);
    compat_i = 0;
  endtask

  task automatic t_waits;
    sector_bound_i = 16'h0000;
    for (int w = 0; w < 4; w++) begin
      ws_upper_i = w[1:0];
      access(1, 16'h2000 + 16'(w), 8'h10 + 8'(w), 0);
      chk($sformatf("R4 ws%0d cycles", w), cyc, 4 + w);
      chk($sformatf("R4 ws%0d strobe", w), wrlow, (w == 3) ? 3 : 1 + w);
      chk($sformatf("R6 ws%0d no rd", w), rdlow, 0);
      chk($sformatf("R3 ws%0d addr phase", w), addr_ok, 1);
    end
  endtask

  task automatic t_sector;
    sector_bound_i = 16'h8000; ws_upper_i = 2'b11; ws_lower_i = 2'b00;
    access(0, 16'h7FFF, 0, 0);
    chk("R5 below bound", cyc, 4);
    access(0, 16'h8000, 0, 0);
    chk("R5 at bound", cyc, 7);
  endtask

  task automatic t_data;
    sector_bound_i = 16'h0000; ws_upper_i = 2'b01;
    access(1, 16'h3344, 8'hA5, 0);
    chk("R6 write strobe", wrlow, 2);
    access(1, 16'h3345, 8'h3C, 0);
    access(0, 16'h3344, 0, 0);
    chk("R7 read A5", rdv, 8'hA5);
    chk("R7 read strobe", rdlow, 2);
    chk("R7 no drive in read", oerd, 0);
    access(0, 16'h3345, 0, 0);
    chk("R7 read 3C", rdv, 8'h3C);
  endtask

  task automatic t_ale;
    sector_bound_i = 16'h0000;
    ws_upper_i = 2'b11;
    access(0, 16'h4000, 0, 1);
    chk("R8 tail ale with ram next", lastale, 1);
    chk("R8 no mid ale", alemid, 0);
    access(0, 16'h4001, 0, 0);
    chk("R8 tail ale no ram next", lastale, 0);
    ws_upper_i = 2'b10;
    access(0, 16'h4002, 0, 1);
    chk("R8 no ale code 10", lastale, 0);
  endtask

  task automatic t_keeper;
    sector_bound_i = 16'h0000; ws_upper_i = 2'b00;
    keeper_en_i = 0;
    access(1, 16'h5000, 8'h5A, 0);
    @(negedge clk);
    chk("R9 keeper off oe", ad_oe_o, 0);
    keeper_en_i = 1;
    access(1, 16'h5001, 8'hC3, 0);
    @(negedge clk);
    chk("R9 keeper on oe", ad_oe_o, 1);
    chk("R9 keeper on value", ad_o, 8'hC3);
    access(0, 16'h5001, 0, 0);
    chk("R9 keeper released in read", oerd, 0);
    keeper_en_i = 0;
  endtask

  task automatic t_ahi;
    sector_bound_i = 16'h0000; ws_upper_i = 2'b00;
    access(0, 16'h9A00, 0, 0);
    repeat (3) @(negedge clk);
    chk("R10 ahi hold", ahi_o, 8'h9A);
  endtask

  task automatic t_b2b;
    sector_bound_i = 16'h0000; ws_upper_i = 2'b00;
    @(negedge clk); req_i = 1; we_i = 0; addr_i = 16'h6010;
    @(negedge clk); req_i = 0;
    chk("R11 busy", ready_o, 0);
    while (!ready_o) @(negedge clk);
    req_i = 1; addr_i = 16'h6177;
    @(negedge clk); req_i = 0;
    chk("R11 back-to-back ale", ale_o, 1);
    chk("R11 back-to-back busy", ready_o, 0);
    chk("R11 back-to-back addr", ad_o, 8'h77);
    while (!ready_o) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; compat_i = 0; keeper_en_i = 0; req_i = 0; we_i = 0;
    nxt_ram_i = 0; sector_bound_i = 16'h8000; ws_upper_i = 0; ws_lower_i = 0;
    addr_i = 0; wdata_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_waits();
    t_sector();
    t_data();
    t_ale();
    t_keeper();
    t_ahi();
    t_b2b();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule